// File: doc/BRIEF.md
# Byte-Wide UV EPROM Mode Controller

This block models the control and output side of a byte-wide, ultraviolet-erasable programmable read-only memory. It turns four control inputs into one of seven operating modes: read, standby, output off, identifier read, program, program verify and program inhibit. The inputs are an active-low chip-enable/program strobe, an active-low output enable, a flag that marks the programming supply as raised, and a flag that selects the identifier readout. It drives a byte-wide data output together with a separate drive-enable that stands for the tri-state control. When the drive-enable is low, the data output is held at zero.

The storage array is an inferred synchronous memory. It starts erased to all ones, and programming can only clear bits. The access time and the output-enable time are not measured in nanoseconds. Each is a count of clock edges held by its own counter, so a late output enable costs nothing as long as it falls inside the window between the two counts. A host or test fixture drives the pins on clock cycles, and the block answers with registered outputs.

Top module: `uvrom_ctrl`

## Requirements
- R1: In read mode (supply flag 0, identifier flag 0, chip enable 0, output enable 0), once access timing is met, dout_en is 1 and dout carries the stored byte at addr. Whenever dout_en is 0, dout is 8'h00.
- R2: If chip enable was high at a clock edge, dout_en is 0 after that edge, whatever the output enable level.
- R3: If chip enable was low and output enable high at an edge, dout_en is 0 after that edge. The access counter keeps counting in this state.
- R4: The access counter clears at any edge where chip enable is high, a program pulse is present, or a program commit takes place. It restarts at 1 when addr differs from its value at the previous edge, and otherwise it increments, saturating at ACC_CYC. The output-enable counter clears whenever either enable is high. Data is driven after the first edge at which the access counter equals ACC_CYC and the output-enable counter equals OE_CYC (ACC_CYC >= 2, OE_CYC >= 1).
- R5: Output enable may fall up to ACC_CYC-OE_CYC edges after chip enable without delaying the edge at which data is first driven.
- R6: A program pulse is an edge with the supply flag 1, chip enable 0 and output enable 1. At the first edge without a pulse, the byte at the last pulsed address becomes (old byte AND the data sampled at the last pulse edge). An erased byte reads 8'hFF.
- R7: With the supply flag 1 and chip enable 1 (inhibit), no byte changes and dout_en is 0.
- R8: With the supply flag 1, chip enable 0 and output enable 0 (verify), the stored byte is driven under the same timing as R4.
- R9: With the supply flag 0 and the identifier flag 1, a read returns 8'h8F when addr bit 0 is 0 and 8'h85 when it is 1. The identifier flag has no effect when the supply flag is 1.
- R10: Synchronous active-high reset clears dout_en, dout and both counters. It leaves the memory contents as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip enable and program strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_sel | input | 1 | Identifier readout select |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Registered read data, zero when not driven |
| dout_en | output | 1 | Output drive enable (tri-state control) |

## Verification
Five properties are checked on every cycle. The outputs stay undriven after any edge with chip enable or output enable high. Data is never driven unless chip enable was low for the two edges before. Identifier bytes follow the address bit 0 sampled at the edge. A commit never happens unless a pulse with the supply raised came just before it. The exact edge at which data first appears, the restart on an address change, the late output enable window, the AND-only programming result and the lack of any effect from an inhibited pulse can only be shown through the bench's scenarios. The bench compares these against its own model of the array and the counters.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ID_MAKER = 8'h8F;
  localparam logic [BYTE_W-1:0] ID_PART  = 8'h85;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_OUT_OFF,
    MD_READ,
    MD_ID_READ,
    MD_PROGRAM,
    MD_VERIFY,
    MD_INHIBIT
  } mode_e;

endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
  import uvrom_pkg::*;
(
  input  logic  cs_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  id_sel,
  output mode_e mode,
  output logic  drive_req,
  output logic  pulse
);

  // The supply flag outranks the identifier flag.
  always_comb begin
    if (vpp_hi) begin
      if (cs_n)      mode = MD_INHIBIT;
      else if (oe_n) mode = MD_PROGRAM;
      else           mode = MD_VERIFY;
    end else begin
      if (cs_n)        mode = MD_STANDBY;
      else if (oe_n)   mode = MD_OUT_OFF;
      else if (id_sel) mode = MD_ID_READ;
      else             mode = MD_READ;
    end
  end

  always_comb begin
    drive_req = (mode == MD_READ) || (mode == MD_ID_READ) || (mode == MD_VERIFY);
    pulse     = (mode == MD_PROGRAM);
  end

endmodule

// File: rtl/uvrom_access_timer.sv
module uvrom_access_timer #(
  parameter int ADDR_W  = 10,
  parameter int ACC_CYC = 4,
  parameter int OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_ok
);

  localparam int CE_W = $clog2(ACC_CYC + 1);
  localparam int OC_W = $clog2(OE_CYC + 1);
  localparam logic [CE_W-1:0] CE_MAX = CE_W'(ACC_CYC);
  localparam logic [OC_W-1:0] OC_MAX = OC_W'(OE_CYC);

  logic [ADDR_W-1:0] addr_q;
  logic [CE_W-1:0]   ce_cnt, ce_nxt;
  logic [OC_W-1:0]   oc_cnt, oc_nxt;

  always_comb begin
    if (cs_n || clr)          ce_nxt = '0;
    else if (addr != addr_q)  ce_nxt = CE_W'(1);
    else if (ce_cnt != CE_MAX) ce_nxt = ce_cnt + CE_W'(1);
    else                      ce_nxt = ce_cnt;

    if (cs_n || oe_n)          oc_nxt = '0;
    else if (oc_cnt != OC_MAX) oc_nxt = oc_cnt + OC_W'(1);
    else                       oc_nxt = oc_cnt;

    acc_ok = (ce_nxt == CE_MAX) && (oc_nxt == OC_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ce_cnt <= '0;
      oc_cnt <= '0;
    end else begin
      addr_q <= addr;
      ce_cnt <= ce_nxt;
      oc_cnt <= oc_nxt;
    end
  end

endmodule

// File: rtl/uvrom_array.sv
module uvrom_array
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rd_data,
  output logic              commit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              pgm_q;
  logic [ADDR_W-1:0] pa_q;
  logic [BYTE_W-1:0] pd_q;

  // Erased state: every bit one.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  assign commit = pgm_q && !pulse;

  // Synchronous read, read-before-write; write clears bits only.
  always_ff @(posedge clk) begin
    rd_data <= mem[addr];
    if (commit) mem[pa_q] <= rd_data & pd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_q <= 1'b0;
      pa_q  <= '0;
      pd_q  <= '1;
    end else begin
      pgm_q <= pulse;
      if (pulse) begin
        pa_q <= addr;
        pd_q <= din;
      end
    end
  end

endmodule

// File: rtl/uvrom_out_stage.sv
module uvrom_out_stage
  import uvrom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  input  logic              sel_id,
  input  logic              addr0,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= drive;
      if (!drive)      dout <= '0;
      else if (sel_id) dout <= addr0 ? ID_PART : ID_MAKER;
      else             dout <= rd_data;
    end
  end

endmodule

// File: rtl/uvrom_ctrl.sv
module uvrom_ctrl
  import uvrom_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int ACC_CYC = 4,
  parameter int OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  mode_e             mode;
  logic              drive_req, pulse, commit, acc_ok;
  logic [BYTE_W-1:0] rd_data;

  uvrom_mode_dec i_dec (
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .vpp_hi    (vpp_hi),
    .id_sel    (id_sel),
    .mode      (mode),
    .drive_req (drive_req),
    .pulse     (pulse)
  );

  uvrom_access_timer #(
    .ADDR_W  (ADDR_W),
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC)
  ) i_timer (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .clr    (pulse || commit),
    .addr   (addr),
    .acc_ok (acc_ok)
  );

  uvrom_array #(.ADDR_W(ADDR_W)) i_array (
    .clk     (clk),
    .rst     (rst),
    .pulse   (pulse),
    .addr    (addr),
    .din     (din),
    .rd_data (rd_data),
    .commit  (commit)
  );

  uvrom_out_stage i_out (
    .clk     (clk),
    .rst     (rst),
    .drive   (drive_req && acc_ok),
    .sel_id  (mode == MD_ID_READ),
    .addr0   (addr[0]),
    .rd_data (rd_data),
    .dout    (dout),
    .dout_en (dout_en)
  );

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !dout_en); // R2

  AST_OE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    $past(oe_n) |-> !dout_en); // R3

  AST_ACCESS_MIN: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> ($past(!cs_n) && $past(!cs_n, 2))); // R4

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(id_sel && !vpp_hi)) |->
      (dout == ($past(addr[0]) ? ID_PART : ID_MAKER))); // R9

  AST_COMMIT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    commit |-> ($past(vpp_hi) && $past(!cs_n) && $past(oe_n))); // R6

endmodule

// File: tb/test_uvrom_ctrl.sv
module test_uvrom_ctrl;

  localparam int AW  = 10;
  localparam int ACC = 4;
  localparam int OEC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  uvrom_ctrl #(.ADDR_W(AW), .ACC_CYC(ACC), .OE_CYC(OEC)) i_uvrom_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_sel(id_sel), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // Reference model of the requirements.
  logic [7:0]    sh [1 << AW];
  int            m_ce, m_oc;
  logic          m_pgm;
  logic [AW-1:0] m_aq, m_pa;
  logic [7:0]    m_pd;
  logic          e_en;
  logic [7:0]    e_d;

  function automatic logic [7:0] id_byte(input logic b0);
    return b0 ? 8'h85 : 8'h8F;
  endfunction

  task automatic model_reset();
    m_ce = 0; m_oc = 0; m_pgm = 1'b0; m_aq = '0; m_pa = '0; m_pd = 8'hFF;
    e_en = 1'b0; e_d = 8'h00;
  endtask

  task automatic model_edge();
    logic pulse, commit, valid;
    pulse  = vpp_hi && !cs_n && oe_n;
    commit = m_pgm && !pulse;
    if (commit) sh[m_pa] = sh[m_pa] & m_pd;
    if (cs_n || pulse || commit) m_ce = 0;
    else if (addr != m_aq)       m_ce = 1;
    else if (m_ce < ACC)         m_ce = m_ce + 1;
    if (cs_n || oe_n)  m_oc = 0;
    else if (m_oc < OEC) m_oc = m_oc + 1;
    valid = !cs_n && !oe_n && (m_ce == ACC) && (m_oc == OEC);
    e_en = valid;
    if (!valid)                  e_d = 8'h00;
    else if (id_sel && !vpp_hi)  e_d = id_byte(addr[0]);
    else                         e_d = sh[addr];
    m_pgm = pulse;
    if (pulse) begin m_pa = addr; m_pd = din; end
    m_aq = addr;
  endtask

  function automatic string auto_tag();
    if (vpp_hi) return cs_n ? "R7" : (oe_n ? "R6" : "R8");
    if (cs_n)   return "R2";
    if (oe_n)   return "R3";
    if (id_sel) return "R9";
    return "R1";
  endfunction

  task automatic compare(input string tag);
    n_chk++;
    if (dout_en !== e_en || dout !== e_d) begin
      n_bad++;
      $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
               tag, dout_en, dout, e_en, e_d);
    end
  endtask

  // Drive at the falling edge, model the rising edge, check at the next falling edge.
  task automatic step(input logic c, input logic o, input logic v, input logic i,
                      input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    string t;
    cs_n = c; oe_n = o; vpp_hi = v; id_sel = i; addr = a; din = d;
    t = (tag == "") ? auto_tag() : tag;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(t);
  endtask

  task automatic hold(input int n, input logic c, input logic o, input logic v,
                      input logic i, input logic [AW-1:0] a, input logic [7:0] d,
                      input string tag);
    for (int k = 0; k < n; k++) step(c, o, v, i, a, d, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < (1 << AW); k++) sh[k] = 8'hFF;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R10");                       // R10 reset state
    rst = 1'b0;

    // R4: data first driven after the ACC-th edge, not before
    hold(ACC, 1'b0, 1'b0, 1'b0, 1'b0, AW'(5), 8'h00, "R4");
    // R4: address change restarts the access count
    hold(ACC, 1'b0, 1'b0, 1'b0, 1'b0, AW'(6), 8'h00, "R4");
    // R2: standby floats outputs with output enable low
    hold(2, 1'b1, 1'b0, 1'b0, 1'b0, AW'(6), 8'h00, "R2");
    // R5: late output enable inside the window
    hold(ACC - OEC, 1'b0, 1'b1, 1'b0, 1'b0, AW'(9), 8'h00, "R5");
    hold(OEC + 1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(9), 8'h00, "R5");
    // R6 / R8: program A5 into 3, then 0F over it gives 05
    step(1'b1, 1'b1, 1'b1, 1'b0, AW'(3), 8'hA5, "R7");
    hold(2, 1'b0, 1'b1, 1'b1, 1'b0, AW'(3), 8'hA5, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b0, AW'(3), 8'hA5, "R6");
    hold(ACC + 1, 1'b0, 1'b0, 1'b1, 1'b0, AW'(3), 8'h00, "R8");
    step(1'b1, 1'b1, 1'b1, 1'b0, AW'(3), 8'h0F, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, AW'(3), 8'h0F, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b0, AW'(3), 8'h0F, "R6");
    hold(ACC + 1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(3), 8'h00, "R6");
    // R7: inhibited strobe leaves byte 4 erased
    hold(3, 1'b1, 1'b1, 1'b1, 1'b0, AW'(4), 8'h00, "R7");
    hold(ACC + 1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(4), 8'h00, "R7");
    // R9: identifier bytes, and identifier ignored under raised supply
    hold(ACC + 1, 1'b0, 1'b0, 1'b0, 1'b1, AW'(0), 8'h00, "R9");
    hold(ACC + 1, 1'b0, 1'b0, 1'b0, 1'b1, AW'(1), 8'h00, "R9");
    hold(ACC + 1, 1'b0, 1'b0, 1'b1, 1'b1, AW'(3), 8'h00, "R9");
    // R3: output enable high floats outputs
    hold(2, 1'b0, 1'b1, 1'b0, 1'b0, AW'(3), 8'h00, "R3");

    // Constrained random segments
    for (int s = 0; s < 600; s++) begin
      logic c, o, v, i;
      logic [AW-1:0] a;
      logic [7:0] d;
      c = ($urandom_range(0, 99) < 25);
      o = ($urandom_range(0, 99) < 30);
      v = ($urandom_range(0, 99) < 20);
      i = ($urandom_range(0, 99) < 15);
      a = ($urandom_range(0, 9) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
      d = 8'($urandom);
      hold($urandom_range(1, 8), c, o, v, i, a, d, "");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule